// File: doc/BRIEF.md
# Timer Time-Base with Buffered Reload

This block is the counting core of a general-purpose timer. A clock divider turns the input clock into count steps. A counter then walks those steps toward a reload limit. The counter can run upward, run downward, or bounce between zero and the limit (center-aligned). At each turning point of the chosen pattern it emits a one-clock update pulse. Compare channels use the live count, the current direction and that pulse to build PWM waveforms.

Software programs the block through a single write port with four addresses. A control word selects run or stop, the edge-aligned direction, the alignment mode and whether reload writes are buffered. The divider ratio and the reload limit have their own addresses. A command address forces an update on demand. The divider ratio is always buffered. The reload limit is buffered only when the control word asks for it. A buffered value reaches the active copy at the next update event, natural or forced.

Top module: `tmr_timebase`

## Requirements
- R1: After a synchronous active-low reset, `count_val` is 0, `count_down` is 0 and `upd_pulse` is 0. All internal settings are 0, and the counter is stopped.
- R2: Address 0 is the control word: bit 0 = run, bit 1 = down, bits 3:2 = alignment, bit 4 = reload buffering. With alignment 00, down=0 counts up and down=1 counts down. Any nonzero alignment selects center-aligned counting, and the down bit then has no effect on the count or on `count_down`.
- R3: Address 1 holds the divide ratio minus one (P). The counter steps once every P+1 clocks. A new P becomes active only at an update event, and a forced update restarts the divider phase.
- R4: When counting up, the count goes 0,1,...,L, where L is the active limit from address 2. The step after L wraps the count to 0 and raises `upd_pulse` in the clock where 0 first shows.
- R5: When counting down, the count goes L,...,1,0. The step after 0 reloads the limit and raises `upd_pulse` in the clock where the reloaded value first shows. `count_down` is 1.
- R6: In center-aligned mode the count rises from 0 to L and then falls back to 0, with neither endpoint repeated. `upd_pulse` is high in the clock where L is reached and in the clock where 0 is reached. `count_down` is 1 while the count falls.
- R7: In edge-aligned modes, successive update pulses are (P+1)*(L+1) clocks apart.
- R8: With reload buffering on, a write to address 2 leaves the active limit unchanged until the next update event.
- R9: With reload buffering off, a write to address 2 changes the active limit at once. A count already above the new limit wraps at the next step.
- R10: Writing 1 to bit 0 of address 3 forces an update. This loads both buffered values and restarts the divider. It sets the count to 0, or to the limit when counting down, and sets the center-aligned direction to up. It raises `upd_pulse` for exactly one clock, and the command needs no clearing.
- R11: While run is 0 the count does not change, except through a forced update.
- R12: With a limit of 0 in an edge-aligned mode, the count stays at 0 and every step raises `upd_pulse`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe for the settings port |
| wr_addr | input | 2 | Write address: 0 control, 1 divider, 2 limit, 3 command |
| wr_data | input | DATA_W | Write data |
| count_val | output | DATA_W | Current count |
| count_down | output | 1 | 1 while the counter is moving downward |
| upd_pulse | output | 1 | One-clock update event pulse |

## Verification
The counting function is tried against a table of settings. The table covers both edge-aligned directions, all three nonzero alignment codes (one of them with the down bit set), divider ratios of 1, 2 and 3, and limits of 0 and above. Each run stops after a chosen number of clocks and compares the final count, the direction output and the number of update pulses. This separates wrap-to-zero from reload-from-limit and shows whether a center-aligned endpoint is repeated. It also exposes a divider that is off by one clock. Directed sequences then write the limit mid-run with buffering on and off, force an update mid-period, hold the counter stopped, and measure the clock distance between two update pulses.

// File: rtl/tmr_pkg.sv
// Shared definitions for the timer time-base: write-port addresses and the
// layout of the control word. Assumes the write data path is at least 5 bits.
package tmr_pkg;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_DIV  = 2'd1;
    localparam logic [1:0] ADDR_LIM  = 2'd2;
    localparam logic [1:0] ADDR_CMD  = 2'd3;

    localparam int CTRL_W = 5;

    // Control word, MSB first: buffering, alignment[1:0], down, run
    typedef struct packed {
        logic       preload;
        logic [1:0] align;
        logic       down;
        logic       run;
    } tmr_ctrl_t;

endpackage

// File: rtl/tmr_regs.sv
// Settings block: decodes the write port, holds the control word, and keeps
// the buffered and active copies of the divide ratio and the reload limit.
// Assumes upd_evt is the update event that takes effect at this clock edge.
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              upd_evt,
    output logic              run_en,
    output logic              dir_sel,
    output logic [1:0]        align,
    output logic              force_upd,
    output logic [DATA_W-1:0] div_act,
    output logic [DATA_W-1:0] lim_act,
    output logic [DATA_W-1:0] lim_buf
);

    tmr_ctrl_t         ctrl_q;
    logic [DATA_W-1:0] div_buf;
    logic              wr_ctrl, wr_div, wr_lim;

    assign wr_ctrl   = wr_en && (wr_addr == ADDR_CTRL);
    assign wr_div    = wr_en && (wr_addr == ADDR_DIV);
    assign wr_lim    = wr_en && (wr_addr == ADDR_LIM);
    // command bit is a pulse: nothing is stored, so it clears itself
    assign force_upd = wr_en && (wr_addr == ADDR_CMD) && wr_data[0];

    assign run_en  = ctrl_q.run;
    assign dir_sel = ctrl_q.down;
    assign align   = ctrl_q.align;

    // Control word register
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= tmr_ctrl_t'(wr_data[CTRL_W-1:0]);
    end

    // Buffered copies, written straight from the port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_buf <= '0;
            lim_buf <= '0;
        end else begin
            if (wr_div) div_buf <= wr_data;
            if (wr_lim) lim_buf <= wr_data;
        end
    end

    // Active divide ratio: always loaded on an update event
    always_ff @(posedge clk) begin
        if (!rst_n)       div_act <= '0;
        else if (upd_evt) div_act <= div_buf;
    end

    // Active limit: direct write when unbuffered, else loaded on update
    always_ff @(posedge clk) begin
        if (!rst_n)                         lim_act <= '0;
        else if (wr_lim && !ctrl_q.preload) lim_act <= wr_data;
        else if (upd_evt)                   lim_act <= lim_buf;
    end

    // R8
    lim_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.preload && !upd_evt) |=> $stable(lim_act));

endmodule

// File: rtl/tmr_prescale.sv
// Clock divider: issues one step strobe every (div_act+1) clocks while run is
// set. A restart clears the phase. Assumes div_act only changes on an update,
// which always coincides with a step or a restart.
module tmr_prescale #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             restart,
    input  logic [DIV_W-1:0] div_act,
    output logic             step
);

    logic [DIV_W-1:0] phase_q;

    assign step = run_en && !restart && (phase_q == div_act);

    // Divider phase counter
    always_ff @(posedge clk) begin
        if (!rst_n)       phase_q <= '0;
        else if (restart) phase_q <= '0;
        else if (run_en)  phase_q <= (phase_q == div_act) ? '0 : phase_q + 1'b1;
    end

    // R3
    div_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q <= div_act);

endmodule

// File: rtl/tmr_step.sv
// Counter core: moves the count on each step strobe according to the
// alignment mode and direction, flags update events, and registers the
// event into a one-clock output pulse. Assumes at most one strobe per clock.
module tmr_step #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             force_upd,
    input  logic [1:0]       align,
    input  logic             dir_sel,
    input  logic [CNT_W-1:0] lim_act,
    input  logic [CNT_W-1:0] lim_buf,
    output logic [CNT_W-1:0] cnt_q,
    output logic             dir_q,
    output logic             upd_evt,
    output logic             upd_q
);

    logic             center;
    logic [CNT_W-1:0] nxt_cnt;
    logic             nxt_dir;

    assign center = (align != 2'b00);

    // Next count, direction and update event
    always_comb begin
        nxt_cnt = cnt_q;
        nxt_dir = dir_q;
        upd_evt = 1'b0;
        if (force_upd) begin
            upd_evt = 1'b1;
            nxt_dir = center ? 1'b0 : dir_sel;
            nxt_cnt = (!center && dir_sel) ? lim_buf : '0;
        end else begin
            if (!center) nxt_dir = dir_sel;
            if (step) begin
                if (!center && !dir_sel) begin
                    if (cnt_q >= lim_act) begin
                        nxt_cnt = '0;
                        upd_evt = 1'b1;
                    end else begin
                        nxt_cnt = cnt_q + 1'b1;
                    end
                end else if (!center) begin
                    if (cnt_q == '0) begin
                        nxt_cnt = lim_buf;
                        upd_evt = 1'b1;
                    end else begin
                        nxt_cnt = cnt_q - 1'b1;
                    end
                end else begin
                    if (!dir_q) begin
                        if (cnt_q >= lim_act) begin
                            nxt_dir = 1'b1;
                            nxt_cnt = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
                        end else begin
                            nxt_cnt = cnt_q + 1'b1;
                        end
                    end else begin
                        if (cnt_q == '0) begin
                            nxt_dir = 1'b0;
                            nxt_cnt = (lim_act == '0) ? '0 : CNT_W'(1);
                        end else begin
                            nxt_cnt = cnt_q - 1'b1;
                        end
                    end
                    upd_evt = nxt_dir ? (nxt_cnt == '0) : (nxt_cnt >= lim_act);
                end
            end
        end
    end

    // Count, direction and pulse registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            dir_q <= 1'b0;
            upd_q <= 1'b0;
        end else begin
            cnt_q <= nxt_cnt;
            dir_q <= nxt_dir;
            upd_q <= upd_evt;
        end
    end

    // R11
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !force_upd) |=> $stable(cnt_q));

    // R4
    up_wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_q && $past(!center && !dir_sel)) |-> (cnt_q == '0));

    // R6
    center_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !force_upd && center && lim_act != '0) |=> (cnt_q != $past(cnt_q)));

    // R10
    force_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_upd |=> upd_q);

endmodule

// File: rtl/tmr_timebase.sv
// Timer time-base top: ties the settings block, the clock divider and the
// counter core together. Assumes DATA_W >= 5 so the control word fits.
module tmr_timebase #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] count_val,
    output logic              count_down,
    output logic              upd_pulse
);

    logic              run_en, dir_sel, force_upd, step, upd_evt;
    logic [1:0]        align;
    logic [DATA_W-1:0] div_act, lim_act, lim_buf;

    tmr_regs #(.DATA_W(DATA_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .upd_evt(upd_evt), .run_en(run_en),
        .dir_sel(dir_sel), .align(align), .force_upd(force_upd),
        .div_act(div_act), .lim_act(lim_act), .lim_buf(lim_buf)
    );

    tmr_prescale #(.DIV_W(DATA_W)) div_i (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .restart(force_upd),
        .div_act(div_act), .step(step)
    );

    tmr_step #(.CNT_W(DATA_W)) core_i (
        .clk(clk), .rst_n(rst_n), .step(step), .force_upd(force_upd),
        .align(align), .dir_sel(dir_sel), .lim_act(lim_act),
        .lim_buf(lim_buf), .cnt_q(count_val), .dir_q(count_down),
        .upd_evt(upd_evt), .upd_q(upd_pulse)
    );

endmodule

// File: tb/tmr_timebase_tb_top.sv
`timescale 1ns/1ps
module tmr_timebase_tb_top;

    localparam int DW = 16;
    localparam int NV = 9;

    // table: control, divider, limit, run clocks, expected count, pulses, dir
    localparam logic [7:0]  V_CTRL [NV] = '{8'h01, 8'h01, 8'h03, 8'h03, 8'h05, 8'h09, 8'h0F, 8'h01, 8'h03};
    localparam logic [15:0] V_DIV  [NV] = '{16'd0, 16'd2, 16'd0, 16'd1, 16'd0, 16'd0, 16'd1, 16'd0, 16'd0};
    localparam logic [15:0] V_LIM  [NV] = '{16'd4, 16'd3, 16'd5, 16'd2, 16'd3, 16'd4, 16'd3, 16'd0, 16'd0};
    localparam int          V_RUN  [NV] = '{13, 20, 8, 15, 7, 6, 17, 5, 5};
    localparam logic [15:0] V_CNT  [NV] = '{16'd3, 16'd2, 16'd3, 16'd1, 16'd1, 16'd2, 16'd2, 16'd0, 16'd0};
    localparam int          V_UPD  [NV] = '{2, 1, 1, 2, 2, 1, 2, 5, 5};
    localparam logic        V_DIR  [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] count_val;
    logic          count_down;
    logic          upd_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tmr_timebase #(.DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .count_val(count_val), .count_down(count_down),
        .upd_pulse(upd_pulse)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // called at a falling edge; uses exactly one rising edge
    task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run(input int n, output int pulses);
        pulses = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (upd_pulse) pulses++;
        end
    endtask

    task automatic setup(input logic [7:0] ctrl, input logic [15:0] dv, input logic [15:0] lim);
        wr(2'd0, DW'(ctrl & 8'hFE));
        wr(2'd1, dv);
        wr(2'd2, lim);
        wr(2'd3, 16'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int p;
        string tag;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "count", int'(count_val), 0);
        check("R1", "dir", int'(count_down), 0);
        check("R1", "pulse", int'(upd_pulse), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // table of settings
        for (int v = 0; v < NV; v++) begin
            if (V_LIM[v] == 0) tag = "R12";
            else if (V_CTRL[v][3:2] != 0) tag = "R6/R2";
            else if (V_CTRL[v][1]) tag = "R5/R2";
            else tag = (V_DIV[v] != 0) ? "R4/R3" : "R4";
            setup(V_CTRL[v], V_DIV[v], V_LIM[v]);
            // R10 forced update start value
            check("R10", "start count",
                  int'(count_val), (V_CTRL[v][3:2] == 0 && V_CTRL[v][1]) ? int'(V_LIM[v]) : 0);
            wr(2'd0, DW'(V_CTRL[v]));
            run(V_RUN[v], p);
            check(tag, "final count", int'(count_val), int'(V_CNT[v]));
            check(tag, "pulses", p, V_UPD[v]);
            check(tag, "dir", int'(count_down), int'(V_DIR[v]));
        end

        // R8 buffered limit write
        setup(8'h10, 16'd0, 16'd9);
        wr(2'd0, 16'h11);
        run(3, p);
        wr(2'd2, 16'd2);
        check("R8", "count at write", int'(count_val), 4);
        run(3, p);
        check("R8", "old limit still used", int'(count_val), 7);
        run(3, p);
        check("R8", "wrap at old limit", int'(count_val), 0);
        check("R8", "pulse at wrap", int'(upd_pulse), 1);
        run(3, p);
        check("R8", "wrap at new limit", int'(count_val), 0);
        check("R8", "pulses with new limit", p, 1);

        // R9 unbuffered limit write
        setup(8'h00, 16'd0, 16'd9);
        wr(2'd0, 16'h01);
        run(3, p);
        wr(2'd2, 16'd2);
        run(1, p);
        check("R9", "count above new limit wraps", int'(count_val), 0);
        check("R9", "pulse", int'(upd_pulse), 1);

        // R10 forced update mid-run, R3 divider restart
        setup(8'h00, 16'd3, 16'd9);
        wr(2'd0, 16'h01);
        run(10, p);
        check("R3", "count after 10 clocks", int'(count_val), 2);
        wr(2'd3, 16'd1);
        check("R10", "count after force", int'(count_val), 0);
        check("R10", "pulse after force", int'(upd_pulse), 1);
        run(1, p);
        check("R10", "pulse self-clears", int'(upd_pulse), 0);
        run(2, p);
        check("R3", "no step before ratio", int'(count_val), 0);
        run(1, p);
        check("R3", "step after restart", int'(count_val), 1);

        // R11 stopped counter holds
        setup(8'h02, 16'd0, 16'd6);
        check("R10", "down start at limit", int'(count_val), 6);
        run(10, p);
        check("R11", "held while stopped", int'(count_val), 6);
        check("R11", "no pulses while stopped", p, 0);
        wr(2'd0, 16'h03);
        run(2, p);
        check("R11", "counts after enable", int'(count_val), 4);

        // R7 period measurement
        setup(8'h00, 16'd2, 16'd4);
        wr(2'd0, 16'h01);
        p = 0;
        for (int i = 0; i < 100 && !upd_pulse; i++) @(negedge clk);
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            p++;
            if (upd_pulse) break;
        end
        check("R7", "clocks between pulses", p, 15);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule